// File: doc/BRIEF.md
# Instruction Legality Trap Checker

This block sits next to an instruction decoder. For each decoded instruction it decides whether the instruction must raise an illegal-instruction exception or a virtual-instruction exception. When an exception is due, it also produces the cause code and the trap value. The decoder supplies the raw instruction word and a few decoded flags: CSR access, write intent, floating-point with a rounding field, and "forbidden while virtualized". The hart supplies its privilege level, the virtualization bit, the dynamic rounding mode and which supervisor and hypervisor extensions are present.

The checks are combinational. The result is registered once, on the cycle the decoder asserts its valid strobe, so the trap pulse appears one clock later. The CSR address is taken from instruction bits [31:20]. The static rounding field is taken from bits [14:12]. Whichever exception is raised, the trap value carries the whole instruction word, so the handler can emulate or report the instruction without fetching it again.

Top module: `insn_legality_chk`

## Requirements
- R1: Whenever `trap_o` is 1, `tval_o` equals the full 32-bit instruction word that was presented with `valid_i` one cycle earlier, and never zero for a nonzero instruction.
- R2: Outputs are registered. `trap_o`, `cause_o` and `tval_o` reflect the instruction sampled at the previous rising edge with `valid_i`=1. They are all zero after an edge where `valid_i` was 0 or no check failed.
- R3: When `is_fp_rm_i` is 1, the rounding field `insn_i[14:12]` is used as is, except that the value 7 is replaced by `frm_i`. A resolved mode above 4 raises an illegal-instruction trap (cause 2). When `is_fp_rm_i` is 0, the field is ignored.
- R4: A CSR whose address bits [11:10] are both 1 is read-only. A write to it (`csr_wr_i`=1) is a violation, from any privilege level. A read of it is not a violation by itself.
- R5: The required privilege of a CSR is address bits [9:8] (0 user, 1 supervisor, 2 hypervisor-supervisor, 3 machine). Privilege levels use the same encoding. The effective level is 2 when `priv_i`=1 and `virt_i`=0, and `priv_i` otherwise. An effective level below the required one is a violation.
- R6: A CSR violation raises a virtual-instruction trap (cause 22) when the required privilege is 2. Otherwise it raises an illegal-instruction trap (cause 2).
- R7: A CSR requiring level 1 while `ext_s_i`=0, or level 2 while `ext_h_i`=0, raises an illegal-instruction trap (cause 2), whatever R4 to R6 would decide.
- R8: An instruction flagged `novirt_i`=1 raises a virtual-instruction trap (cause 22) when `virt_i`=1. It raises no trap when `virt_i`=0.
- R9: When several checks fail, the outcome is taken in this order: unsupported CSR mode, bad rounding mode, forbidden-while-virtualized, CSR permission.
- R10: Asserting `rst_ni` low clears all three outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Raw instruction word |
| priv_i | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Virtualization active |
| frm_i | input | 3 | Dynamic rounding mode |
| ext_s_i | input | 1 | Supervisor extension present |
| ext_h_i | input | 1 | Hypervisor extension present |
| is_csr_i | input | 1 | Instruction accesses a CSR |
| csr_wr_i | input | 1 | CSR access writes |
| is_fp_rm_i | input | 1 | Instruction carries a rounding field |
| novirt_i | input | 1 | Instruction forbidden while virtualized |
| trap_o | output | 1 | Exception raised for previous instruction |
| cause_o | output | 5 | Cause code: 2 illegal, 22 virtual, 0 none |
| tval_o | output | 32 | Trap value: faulting instruction word, 0 if none |

## Verification
There is no internal state apart from the output register. A wrong decision therefore shows up on the trap pulse exactly one clock after the offending instruction: either a missing or spurious `trap_o`, or a wrong cause of 2 against 22. The hardest faults to see are in the privilege remap and in the check ordering. They only show when supervisor mode with virtualization off meets a hypervisor CSR, or when two checks fail together. The vectors cover those pairings directly. A stale or zeroed trap value shows in the same cycle as the pulse.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam int unsigned CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRTUAL = 5'd22;

  localparam int unsigned LVL_W = 2;
  localparam logic [LVL_W-1:0] LVL_U  = 2'd0;
  localparam logic [LVL_W-1:0] LVL_S  = 2'd1;
  localparam logic [LVL_W-1:0] LVL_HS = 2'd2;

  localparam int unsigned RM_W = 3;
  localparam logic [RM_W-1:0] RM_DYNAMIC    = 3'd7;
  localparam logic [RM_W-1:0] RM_LAST_VALID = 3'd4;

  localparam int unsigned NUM_CHECKS = 4;
endpackage

// File: rtl/ilc_rm_check.sv
module ilc_rm_check
  import ilc_pkg::*;
(
  input  logic            en_i,
  input  logic [RM_W-1:0] rm_field_i,
  input  logic [RM_W-1:0] frm_i,
  output logic            bad_o
);
  logic [RM_W-1:0] rm_eff;

  always_comb begin
    rm_eff = (rm_field_i == RM_DYNAMIC) ? frm_i : rm_field_i;
    bad_o  = en_i && (rm_eff > RM_LAST_VALID);
  end
endmodule

// File: rtl/ilc_csr_check.sv
module ilc_csr_check
  import ilc_pkg::*;
(
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [3:0]       addr_hi_i,   // CSR address bits [11:8]
  input  logic [LVL_W-1:0] priv_i,
  input  logic             virt_i,
  input  logic             ext_s_i,
  input  logic             ext_h_i,
  output logic             unsup_o,
  output logic             viol_o,
  output logic             viol_virtual_o
);
  logic             read_only;
  logic [LVL_W-1:0] req_lvl;
  logic [LVL_W-1:0] eff_lvl;

  always_comb begin
    read_only = &addr_hi_i[3:2];
    req_lvl   = addr_hi_i[1:0];
    // supervisor outside a guest runs at hypervisor-supervisor level
    eff_lvl   = (priv_i == LVL_S && !virt_i) ? LVL_HS : priv_i;
    unsup_o   = en_i && ((req_lvl == LVL_S  && !ext_s_i) ||
                         (req_lvl == LVL_HS && !ext_h_i));
    viol_o    = en_i && ((wr_i && read_only) || (eff_lvl < req_lvl));
    viol_virtual_o = (req_lvl == LVL_HS);
  end
endmodule

// File: rtl/ilc_trap_arb.sv
module ilc_trap_arb
  import ilc_pkg::*;
(
  input  logic               unsup_i,
  input  logic               rm_bad_i,
  input  logic               novirt_i,
  input  logic               csr_viol_i,
  input  logic               csr_virtual_i,
  output logic               raise_o,
  output logic [CAUSE_W-1:0] cause_o
);
  // index 0 is highest priority
  logic [NUM_CHECKS-1:0]   hit;
  logic [CAUSE_W-1:0]      code [NUM_CHECKS];

  always_comb begin
    hit     = {csr_viol_i, novirt_i, rm_bad_i, unsup_i};
    code[0] = CAUSE_ILLEGAL;
    code[1] = CAUSE_ILLEGAL;
    code[2] = CAUSE_VIRTUAL;
    code[3] = csr_virtual_i ? CAUSE_VIRTUAL : CAUSE_ILLEGAL;
    raise_o = |hit;
    cause_o = '0;
    for (int i = NUM_CHECKS - 1; i >= 0; i--) begin
      if (hit[i]) cause_o = code[i];
    end
  end
endmodule

// File: rtl/insn_legality_chk.sv
module insn_legality_chk
  import ilc_pkg::*;
#(
  parameter int unsigned ILEN    = 32,
  parameter int unsigned RM_LSB  = 12,
  parameter int unsigned CSR_LSB = 20,
  parameter int unsigned CSR_AW  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ILEN-1:0]    insn_i,
  input  logic [LVL_W-1:0]   priv_i,
  input  logic               virt_i,
  input  logic [RM_W-1:0]    frm_i,
  input  logic               ext_s_i,
  input  logic               ext_h_i,
  input  logic               is_csr_i,
  input  logic               csr_wr_i,
  input  logic               is_fp_rm_i,
  input  logic               novirt_i,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [ILEN-1:0]    tval_o
);
  localparam int unsigned CSR_MSB = CSR_LSB + CSR_AW - 1;
  localparam int unsigned RM_MSB  = RM_LSB + RM_W - 1;

  logic               rm_bad, unsup, csr_viol, csr_virtual, nv_hit, raise;
  logic [CAUSE_W-1:0] cause_d;

  ilc_rm_check u_rm (
    .en_i       (is_fp_rm_i),
    .rm_field_i (insn_i[RM_MSB:RM_LSB]),
    .frm_i      (frm_i),
    .bad_o      (rm_bad)
  );

  ilc_csr_check u_csr (
    .en_i           (is_csr_i),
    .wr_i           (csr_wr_i),
    .addr_hi_i      (insn_i[CSR_MSB -: 4]),
    .priv_i         (priv_i),
    .virt_i         (virt_i),
    .ext_s_i        (ext_s_i),
    .ext_h_i        (ext_h_i),
    .unsup_o        (unsup),
    .viol_o         (csr_viol),
    .viol_virtual_o (csr_virtual)
  );

  assign nv_hit = novirt_i && virt_i;

  ilc_trap_arb u_arb (
    .unsup_i       (unsup),
    .rm_bad_i      (rm_bad),
    .novirt_i      (nv_hit),
    .csr_viol_i    (csr_viol),
    .csr_virtual_i (csr_virtual),
    .raise_o       (raise),
    .cause_o       (cause_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o  <= 1'b0;
      cause_o <= '0;
      tval_o  <= '0;
    end else if (valid_i && raise) begin
      trap_o  <= 1'b1;
      cause_o <= cause_d;
      tval_o  <= insn_i;
    end else begin
      trap_o  <= 1'b0;
      cause_o <= '0;
      tval_o  <= '0;
    end
  end
endmodule

// File: rtl/ilc_checker.sv
module ilc_checker
  import ilc_pkg::*;
#(
  parameter int unsigned ILEN = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [ILEN-1:0]    insn_i,
  input logic               virt_i,
  input logic               is_csr_i,
  input logic               is_fp_rm_i,
  input logic               novirt_i,
  input logic               trap_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [ILEN-1:0]    tval_o
);
  a_r1_tval_is_insn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> tval_o == $past(insn_i));

  a_r2_idle_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !trap_o);

  a_r2_quiet_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (cause_o == '0 && tval_o == '0));

  a_r6_cause_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (cause_o == CAUSE_ILLEGAL || cause_o == CAUSE_VIRTUAL));

  a_r3_static_rm_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_fp_rm_i && (insn_i[14:12] == 3'd5 || insn_i[14:12] == 3'd6))
    |=> (trap_o && cause_o == CAUSE_ILLEGAL));

  a_r8_novirt_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && novirt_i && virt_i && !is_fp_rm_i && !is_csr_i)
    |=> (trap_o && cause_o == CAUSE_VIRTUAL));
endmodule

bind insn_legality_chk ilc_checker #(.ILEN(ILEN)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .insn_i     (insn_i),
  .virt_i     (virt_i),
  .is_csr_i   (is_csr_i),
  .is_fp_rm_i (is_fp_rm_i),
  .novirt_i   (novirt_i),
  .trap_o     (trap_o),
  .cause_o    (cause_o),
  .tval_o     (tval_o)
);

// File: tb/insn_legality_chk_tb_top.sv
`timescale 1ns/1ps
module insn_legality_chk_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [1:0]  priv_i = '0;
  logic        virt_i = 1'b0;
  logic [2:0]  frm_i = '0;
  logic        ext_s_i = 1'b1, ext_h_i = 1'b1;
  logic        is_csr_i = 1'b0, csr_wr_i = 1'b0, is_fp_rm_i = 1'b0, novirt_i = 1'b0;
  logic        trap_o;
  logic [4:0]  cause_o;
  logic [31:0] tval_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  insn_legality_chk dut_i (.*);

  typedef struct packed {
    logic [31:0] insn;
    logic [1:0]  priv;
    logic        virt;
    logic [2:0]  frm;
    logic        es, eh, csr, wr, fp, nv;
    logic        exp;
    logic [4:0]  cause;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  // insn, priv, virt, frm, es, eh, csr, wr, fp, nv, exp, cause, req
  localparam vec_t VECS [NV] = '{
    '{32'h30001073, 2'd3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd5}, // R5 M csr from M
    '{32'h30001073, 2'd1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2,  4'd5}, // R5 M csr from HS
    '{32'h60001073, 2'd1, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd22, 4'd6}, // R6 HS csr from VS
    '{32'h60001073, 2'd1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  4'd5}, // R5 S remapped to HS
    '{32'h10001073, 2'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2,  4'd6}, // R6 S csr from U
    '{32'hC0001073, 2'd3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd2,  4'd4}, // R4 write RO from M
    '{32'hC0001073, 2'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  4'd4}, // R4 read RO from U
    '{32'hF1101073, 2'd3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd2,  4'd4}, // R4 write M RO
    '{32'h10001073, 2'd3, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2,  4'd7}, // R7 no S ext
    '{32'h60001073, 2'd1, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2,  4'd7}, // R7 no H ext beats virtual
    '{32'h00007053, 2'd3, 1'b0, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd2,  4'd3}, // R3 dyn -> 5
    '{32'h00007053, 2'd3, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  4'd3}, // R3 dyn -> 4
    '{32'h00005053, 2'd3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd2,  4'd3}, // R3 static 5
    '{32'h00007053, 2'd3, 1'b0, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd2,  4'd3}, // R3 dyn -> 7
    '{32'h00000053, 2'd3, 1'b0, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  4'd3}, // R3 static 0 ignores frm
    '{32'h10500073, 2'd1, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd22, 4'd8}, // R8 guest
    '{32'h10500073, 2'd1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  4'd8}, // R8 host
    '{32'h00005053, 2'd1, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd2,  4'd9}, // R9 rm before novirt
    '{32'h30001073, 2'd1, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd22, 4'd9}, // R9 novirt before csr
    '{32'h00007033, 2'd3, 1'b0, 3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  4'd3}  // R3 field ignored
  };

  task automatic check(input string tag, input logic et, input logic [4:0] ec,
                       input logic [31:0] ev);
    n_run++;
    if (trap_o !== et || cause_o !== ec || tval_o !== ev) begin
      n_fail++;
      $display("FAIL %s: trap/cause/tval = %0b/%0d/%h, expected %0b/%0d/%h",
               tag, trap_o, cause_o, tval_o, et, ec, ev);
    end
  endtask

  task automatic apply(input vec_t v, input logic vld);
    valid_i = vld; insn_i = v.insn; priv_i = v.priv; virt_i = v.virt;
    frm_i = v.frm; ext_s_i = v.es; ext_h_i = v.eh; is_csr_i = v.csr;
    csr_wr_i = v.wr; is_fp_rm_i = v.fp; novirt_i = v.nv;
  endtask

  initial begin
    #20;
    check("R10 reset", 1'b0, 5'd0, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2 idle after reset", 1'b0, 5'd0, 32'h0);

    // vector table, one instruction per cycle
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], 1'b1);
      @(negedge clk_i);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].exp, VECS[i].cause,
            VECS[i].exp ? VECS[i].insn : 32'h0);
      if (VECS[i].exp) check($sformatf("R1 vec %0d", i), 1'b1, VECS[i].cause, VECS[i].insn);
    end

    // R2: failing instruction without valid gives nothing
    apply(VECS[1], 1'b0);
    @(negedge clk_i);
    check("R2 no valid", 1'b0, 5'd0, 32'h0);

    // R2: trap lasts one cycle only
    apply(VECS[2], 1'b1);
    @(negedge clk_i);
    check("R2 pulse", 1'b1, 5'd22, 32'h60001073);
    apply(VECS[0], 1'b1);
    @(negedge clk_i);
    check("R2 pulse drop", 1'b0, 5'd0, 32'h0);

    // R10: asynchronous clear between edges
    apply(VECS[5], 1'b1);
    @(negedge clk_i);
    check("R10 pre", 1'b1, 5'd2, 32'hC0001073);
    #1 rst_ni = 1'b0;
    #1 check("R10 async clear", 1'b0, 5'd0, 32'h0);
    valid_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 after release", 1'b0, 5'd0, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule